// File: doc/BRIEF.md
# Codec Command Slot Interface

This block sits between a register bus and a codec's control-register model. Software builds a codec command in two slot words. The data word is loaded first. It is only held, and nothing is sent to the codec yet. Writing the command word then fires the access. The command word carries a read/write select and a 7-bit codec register index. The 16-bit payload for writes sits inside the data word.

The block turns that access into a single-cycle request on a small request/response port. For a codec read, it waits for the response pulse. It then places the command word and the returned value, moved into slot position, into two receive registers. A flag register tracks, per slot, whether each transmit word is still empty, whether a read is in flight, and whether unread receive data is waiting. Reading a receive register acknowledges it.

Register map (3-bit address): 0 command transmit, 1 data transmit, 2 command receive, 3 data receive, 4 flags. Flag bits:
- bit 0: command transmit empty
- bit 1: data transmit empty
- bit 2: both transmit words empty
- bit 3: command receive busy
- bit 4: data receive busy
- bit 5: command receive valid
- bit 6: data receive valid

Top module: `codec_slot_if`

## Requirements
- R1: After reset the flag register reads 0x07 (bits 0, 1 and 2 set). All other registers read zero, and `cmdReq` is low.
- R2: A write to address 1 stores the 20-bit word and clears flag bit 1, which also clears bit 2. It issues no codec request.
- R3: A write to address 0 stores the word and clears flag bit 0. In the next cycle `cmdReq` is high for exactly one cycle. During that cycle `cmdAddr` equals word bits [18:12] and `cmdWrite` is the inverse of word bit 19. `cmdData` equals bits [19:4] of the last data word.
- R4: A command with bit 19 set (codec read) sets flag bits 3 and 4 in the cycle its request is issued. Both stay set until the response arrives. A codec write leaves them clear.
- R5: While a read is outstanding, writes to address 0 are ignored. No request is issued, and the command transmit register keeps its value.
- R6: A `rspValid` pulse during an outstanding read does three things. The command receive register gets the command word with bit 19 cleared. The data receive register gets `rspData` shifted left by 4. Flag bits 3 and 4 clear, and bits 5 and 6 set.
- R7: A read of address 2 returns the command receive word and clears flag bit 5. A read of address 3 returns the data receive word and clears flag bit 6.
- R8: A `rspValid` pulse with no read outstanding changes neither receive register nor any flag.
- R9: Addresses 5 to 7 read as zero. Writes to addresses 2 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (acknowledges receive data) |
| regAddr | input | 3 | Register address |
| regWrData | input | 20 | Register write data |
| regRdData | output | 20 | Register read data, combinational from `regAddr` |
| cmdReq | output | 1 | One-cycle codec access request |
| cmdWrite | output | 1 | 1 for codec write, 0 for codec read |
| cmdAddr | output | 7 | Codec register index |
| cmdData | output | 16 | Codec write value |
| rspValid | input | 1 | Codec read response pulse |
| rspData | input | 16 | Codec read value |

## Verification
The bench targets four corner cases:
- **Read polarity.** A design that inverted bit 19 would send a write where a read was asked for. Busy would then never set.
- **Command written while a read is pending.** A design that accepted this command would raise a second request and overwrite the command word before the response returned.
- **Stray response with no read pending.** A design that took it would corrupt the receive registers and raise valid flags.
- **Receive word alignment and per-slot acknowledge.** Here the usual faults are a missing 4-bit shift, a bit 19 left set in the returned command word, or one read clearing both valid flags.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;

  typedef struct packed {
    logic ldCmd;    // accept command word and launch access
    logic ldData;   // accept data word
    logic capture;  // latch read response into receive slots
  } slotStrobe_t;

  localparam int FLAG_W        = 7;
  localparam int F_CMD_EMPTY   = 0;
  localparam int F_DATA_EMPTY  = 1;
  localparam int F_BOTH_EMPTY  = 2;
  localparam int F_CMD_BUSY    = 3;
  localparam int F_DATA_BUSY   = 4;
  localparam int F_CMD_VALID   = 5;
  localparam int F_DATA_VALID  = 6;

  localparam int A_CMD_TX  = 0;
  localparam int A_DATA_TX = 1;
  localparam int A_CMD_RX  = 2;
  localparam int A_DATA_RX = 3;
  localparam int A_FLAGS   = 4;

endpackage

// File: rtl/codec_slot_ctrl.sv
module codec_slot_ctrl
  import codec_slot_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrIsRead,
  input  logic              rspValid,
  output slotStrobe_t       strobe,
  output logic              cmdReq,
  output logic [FLAG_W-1:0] flags
);

  localparam logic [ADDR_W-1:0] ADDR_CMD_TX  = ADDR_W'(A_CMD_TX);
  localparam logic [ADDR_W-1:0] ADDR_DATA_TX = ADDR_W'(A_DATA_TX);
  localparam logic [ADDR_W-1:0] ADDR_CMD_RX  = ADDR_W'(A_CMD_RX);
  localparam logic [ADDR_W-1:0] ADDR_DATA_RX = ADDR_W'(A_DATA_RX);

  logic [1:0] txEmpty;
  logic [1:0] rxBusy;
  logic [1:0] rxValid;
  logic [1:0] rxAck;

  always_comb begin
    strobe.ldCmd   = regWrEn && (regAddr == ADDR_CMD_TX) && !rxBusy[0];
    strobe.ldData  = regWrEn && (regAddr == ADDR_DATA_TX);
    strobe.capture = rspValid && rxBusy[0];
    rxAck[0]       = regRdEn && (regAddr == ADDR_CMD_RX);
    rxAck[1]       = regRdEn && (regAddr == ADDR_DATA_RX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEmpty <= 2'b11;
      rxBusy  <= 2'b00;
      rxValid <= 2'b00;
      cmdReq  <= 1'b0;
    end else begin
      cmdReq <= strobe.ldCmd;
      if (strobe.ldCmd)  txEmpty[0] <= 1'b0;
      if (strobe.ldData) txEmpty[1] <= 1'b0;
      if (strobe.ldCmd && wrIsRead) rxBusy <= 2'b11;
      else if (strobe.capture)      rxBusy <= 2'b00;
      for (int i = 0; i < 2; i++) begin
        if (strobe.capture)  rxValid[i] <= 1'b1;
        else if (rxAck[i])   rxValid[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    flags               = '0;
    flags[F_CMD_EMPTY]  = txEmpty[0];
    flags[F_DATA_EMPTY] = txEmpty[1];
    flags[F_BOTH_EMPTY] = &txEmpty;
    flags[F_CMD_BUSY]   = rxBusy[0];
    flags[F_DATA_BUSY]  = rxBusy[1];
    flags[F_CMD_VALID]  = rxValid[0];
    flags[F_DATA_VALID] = rxValid[1];
  end

  // R5: a command arriving during an outstanding read never issues
  a_r5_no_issue_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    rxBusy[0] |=> !cmdReq);

  // R6: response during a pending read completes it
  a_r6_rsp_completes: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rxBusy[0]) |=> (rxValid == 2'b11 && rxBusy == 2'b00));

  // R3: the command-empty flag never returns once cleared
  a_r3_cmd_empty_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !txEmpty[0] |=> !txEmpty[0]);

  // R8: a stray response with nothing pending leaves valid flags unchanged or lower
  a_r8_stray_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rxBusy[0]) |=> ((rxValid & ~$past(rxValid)) == 2'b00));

endmodule

// File: rtl/codec_slot_datapath.sv
module codec_slot_datapath
  import codec_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 7,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SLOT_W-1:0] regWrData,
  input  logic [VAL_W-1:0]  rspData,
  input  logic [FLAG_W-1:0] flags,
  output logic [SLOT_W-1:0] regRdData,
  output logic              cmdWrite,
  output logic [IDX_W-1:0]  cmdAddr,
  output logic [VAL_W-1:0]  cmdData
);

  localparam int RW_BIT  = SLOT_W - 1;
  localparam int IDX_MSB = RW_BIT - 1;
  localparam int VAL_LSB = SLOT_W - VAL_W;

  logic [SLOT_W-1:0] cmdTx, dataTx, cmdRx, dataRx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdTx  <= '0;
      dataTx <= '0;
      cmdRx  <= '0;
      dataRx <= '0;
    end else begin
      if (strobe.ldCmd)  cmdTx  <= regWrData;
      if (strobe.ldData) dataTx <= regWrData;
      if (strobe.capture) begin
        cmdRx          <= cmdTx;
        cmdRx[RW_BIT]  <= 1'b0;
        dataRx         <= {rspData, {VAL_LSB{1'b0}}};
      end
    end
  end

  assign cmdWrite = !cmdTx[RW_BIT];
  assign cmdAddr  = cmdTx[IDX_MSB -: IDX_W];
  assign cmdData  = dataTx[SLOT_W-1 -: VAL_W];

  always_comb begin
    case (int'(regAddr))
      A_CMD_TX:  regRdData = cmdTx;
      A_DATA_TX: regRdData = dataTx;
      A_CMD_RX:  regRdData = cmdRx;
      A_DATA_RX: regRdData = dataRx;
      A_FLAGS:   regRdData = {{(SLOT_W-FLAG_W){1'b0}}, flags};
      default:   regRdData = '0;
    endcase
  end

  // R6: the returned command word never carries the read select
  a_r6_rx_rw_clear: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRx[RW_BIT]);

endmodule

// File: rtl/codec_slot_if.sv
module codec_slot_if
  import codec_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 7,
  parameter int VAL_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SLOT_W-1:0] regWrData,
  output logic [SLOT_W-1:0] regRdData,
  output logic              cmdReq,
  output logic              cmdWrite,
  output logic [IDX_W-1:0]  cmdAddr,
  output logic [VAL_W-1:0]  cmdData,
  input  logic              rspValid,
  input  logic [VAL_W-1:0]  rspData
);

  slotStrobe_t       strobe;
  logic [FLAG_W-1:0] flags;

  codec_slot_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .wrIsRead(regWrData[SLOT_W-1]), .rspValid(rspValid),
    .strobe(strobe), .cmdReq(cmdReq), .flags(flags)
  );

  codec_slot_datapath #(.SLOT_W(SLOT_W), .IDX_W(IDX_W), .VAL_W(VAL_W),
                        .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .rspData(rspData), .flags(flags),
    .regRdData(regRdData), .cmdWrite(cmdWrite), .cmdAddr(cmdAddr),
    .cmdData(cmdData)
  );

  // R4: a read request goes out with both busy flags raised
  a_r4_read_marks_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdWrite) |-> (flags[F_CMD_BUSY] && flags[F_DATA_BUSY]));

  // R4: a write request leaves busy clear
  a_r4_write_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdWrite) |-> !flags[F_CMD_BUSY]);

endmodule

// File: tb/codec_slot_if_tb_top.sv
module codec_slot_if_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [19:0] regWrData = '0;
  logic [19:0] regRdData;
  logic        cmdReq, cmdWrite;
  logic [6:0]  cmdAddr;
  logic [15:0] cmdData;
  logic        rspValid = 1'b0;
  logic [15:0] rspData = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  codec_slot_if dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmdReq(cmdReq), .cmdWrite(cmdWrite), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [19:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseRsp(input logic [15:0] d);
    @(negedge clk);
    rspValid = 1'b1; rspData = d;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [19:0] v;
    chk("R1", "cmdReq", 32'(cmdReq), 0);
    rdReg(3'd4, v); chk("R1", "flags", 32'(v), 32'h07);
    for (int a = 0; a < 4; a++) begin
      rdReg(3'(a), v); chk("R1", "reg zero", 32'(v), 0);
    end
  endtask

  task automatic t_dataSlot();
    logic [19:0] v;
    wrReg(3'd1, 20'hABCDE);
    chk("R2", "no request", 32'(cmdReq), 0);
    rdReg(3'd1, v); chk("R2", "data readback", 32'(v), 32'hABCDE);
    rdReg(3'd4, v); chk("R2", "flags", 32'(v), 32'h01);
  endtask

  task automatic t_codecWrite();
    logic [19:0] v;
    wrReg(3'd0, (20'h2A << 12) | 20'h123);
    chk("R3", "cmdReq", 32'(cmdReq), 1);
    chk("R3", "cmdAddr", 32'(cmdAddr), 32'h2A);
    chk("R3", "cmdWrite", 32'(cmdWrite), 1);
    chk("R3", "cmdData", 32'(cmdData), 32'hABCD);
    @(negedge clk);
    chk("R3", "cmdReq one cycle", 32'(cmdReq), 0);
    rdReg(3'd4, v); chk("R4", "flags after codec write", 32'(v), 32'h00);
  endtask

  task automatic t_codecRead();
    logic [19:0] v;
    logic [19:0] cw;
    cw = (20'h1 << 19) | (20'h15 << 12) | 20'h00F;
    wrReg(3'd0, cw);
    chk("R3", "read cmdReq", 32'(cmdReq), 1);
    chk("R3", "read cmdWrite", 32'(cmdWrite), 0);
    chk("R3", "read cmdAddr", 32'(cmdAddr), 32'h15);
    rdReg(3'd4, v); chk("R4", "busy flags", 32'(v), 32'h18);
    wrReg(3'd0, 20'h7F000);
    chk("R5", "no request while busy", 32'(cmdReq), 0);
    rdReg(3'd0, v); chk("R5", "cmd word kept", 32'(v), 32'(cw));
    pulseRsp(16'h1234);
    rdReg(3'd4, v); chk("R6", "flags after response", 32'(v), 32'h60);
    rdReg(3'd2, v); chk("R7", "cmd rx word", 32'(v), (32'h15 << 12) | 32'h00F);
    rdReg(3'd4, v); chk("R7", "cmd valid acked", 32'(v), 32'h40);
    rdReg(3'd3, v); chk("R6", "data rx word", 32'(v), 32'h12340);
    rdReg(3'd4, v); chk("R7", "data valid acked", 32'(v), 32'h00);
  endtask

  task automatic t_strayRsp();
    logic [19:0] v;
    pulseRsp(16'hFFFF);
    rdReg(3'd4, v); chk("R8", "flags after stray", 32'(v), 32'h00);
    rdReg(3'd3, v); chk("R8", "data rx kept", 32'(v), 32'h12340);
    rdReg(3'd2, v); chk("R8", "cmd rx kept", 32'(v), (32'h15 << 12) | 32'h00F);
  endtask

  task automatic t_unmapped();
    logic [19:0] v;
    wrReg(3'd2, 20'hFFFFF);
    wrReg(3'd3, 20'h00001);
    wrReg(3'd4, 20'hFFFFF);
    wrReg(3'd5, 20'h55555);
    chk("R9", "no request", 32'(cmdReq), 0);
    rdReg(3'd2, v); chk("R9", "cmd rx kept", 32'(v), (32'h15 << 12) | 32'h00F);
    rdReg(3'd3, v); chk("R9", "data rx kept", 32'(v), 32'h12340);
    rdReg(3'd4, v); chk("R9", "flags kept", 32'(v), 32'h00);
    for (int a = 5; a < 8; a++) begin
      rdReg(3'(a), v); chk("R9", "unmapped reads zero", 32'(v), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_dataSlot();
    t_codecWrite();
    t_codecRead();
    t_strayRsp();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule